// File: doc/BRIEF.md
# Address Translation Unit with Translation Cache

The block sits between a load/store port and the memory system. It converts a virtual address into a physical address. A small fully associative translation cache is searched first. On a hit, the unit checks the access type against the cached permission bits. In the same cycle it either issues the physical address or reports a protection fault, and it makes no page-table access at all. On a miss, it captures the access and asks an external page-table walker for the mapping of the virtual page. It then waits for the walker's answer.

A successful walk writes the page, frame and permission bits into the cache. The captured access is then replayed one cycle later, and the replay now hits. A walk that reports a fault is answered straight away with a segmentation cause code, and the cache is left untouched. A flush input empties the whole cache in one cycle. The flush only takes effect while the unit is idle.

The control is a three-state machine:
- `ST_IDLE` accepts requests and serves hits. A miss (transition *miss*) moves to `ST_WALK`.
- `ST_WALK` holds the walk request. A good walk answer (transition *fill*) moves to `ST_REPLAY`. A faulting walk answer (transition *walk fault*) returns to `ST_IDLE`.
- `ST_REPLAY` looks up the captured access again and responds (transition *replay done*), returning to `ST_IDLE`. If the replay should miss, the *re-walk* transition goes back to `ST_WALK`.

Top module: `xlat_unit`

## Requirements
- R1: The page number is the virtual address shifted right by the 6-bit offset width. On a hit, `rsp_valid` rises in the same cycle as the request, and `rsp_paddr` is the cached frame shifted left by 6, ORed with the offset. For example, 0x3F80 with page 254 mapped to frame 55 gives 0x0DC0.
- R2: A hit raises no walk request (`walk_req_valid` stays 0).
- R3: Permission bits are bit0 read, bit1 write and bit2 execute. Access codes are 0 read, 1 write, 2 execute, and 3 reserved (always denied). A denied access responds with `rsp_fault`=1 and `rsp_paddr`=0. A granted access responds with `rsp_fault`=0.
- R4: On a miss, no response is given in the request cycle. From the next cycle on, `walk_req_valid` is high with `walk_req_vpn` equal to the missing page, and it is held steady until `walk_rsp_valid`. During this time `req_ready` is 0.
- R5: A walk answer without a fault inserts the mapping. The replayed access responds in the cycle after the walk answer, with the R1/R3 result and no new walk.
- R6: A walk answer with a fault responds in that same cycle with `rsp_fault`=2 and `rsp_paddr`=0. Nothing is inserted, so the same access misses again.
- R7: The cache holds 8 entries and is filled in round-robin order. A failed walk does not advance the order. The 9th insert therefore evicts the 1st one.
- R8: `flush` while idle invalidates every entry in one cycle. `req_ready` is 0 during that cycle, and every later access misses.
- R9: `flush` while a walk or replay is outstanding is ignored: the mapping inserted by that walk still hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache entries (idle only) |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_vaddr | input | 14 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response (physical access or fault) valid |
| rsp_paddr | output | 14 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 protection, 2 segmentation |
| walk_req_valid | output | 1 | Page-table walk requested |
| walk_req_vpn | output | 8 | Virtual page to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker found no valid mapping |
| walk_rsp_pfn | input | 8 | Frame number from walker |
| walk_rsp_prot | input | 3 | Permission bits from walker |

## Verification
Translation is exercised in several ways:
- Cold misses show that the walk, fill and replay path works.
- Repeated accesses to the same page with different offsets separate real hits from walks.
- Every access type is applied to both full-permission and partial-permission pages, which tells granted and denied checks apart.

Beyond that, four sequences target specific behaviour:
- A sequence of nine distinct pages, followed by probes of the oldest and next-oldest pages, separates round-robin eviction from any other choice.
- Faulting walks, each repeated, show that no insert and no pointer advance happened.
- An idle flush is followed by accesses to pages that were previously resident.
- A flush is raised during a walk, and that page is then probed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PROT = 2'd1,
        FLT_SEG  = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_REPLAY = 2'd2
    } st_e;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
    localparam int PERM_W  = 3;

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8,
    parameter int ENTRIES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_en,
    input  logic [VPN_W-1:0]          lk_vpn,
    output logic                      lk_hit,
    output logic [PFN_W-1:0]          lk_pfn,
    output logic [xlat_pkg::PERM_W-1:0] lk_perm,
    input  logic                      ins_en,
    input  logic [VPN_W-1:0]          ins_vpn,
    input  logic [PFN_W-1:0]          ins_pfn,
    input  logic [xlat_pkg::PERM_W-1:0] ins_perm
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]               vld_q;
    logic [VPN_W-1:0]                 tag_q  [ENTRIES];
    logic [PFN_W-1:0]                 pfn_q  [ENTRIES];
    logic [xlat_pkg::PERM_W-1:0]      perm_q [ENTRIES];
    logic [IDX_W-1:0]                 victim_q;
    logic [ENTRIES-1:0]               match;

    // Tag compare per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    end

    // One-hot select of the matching entry
    always_comb begin
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_pfn  = lk_pfn  | pfn_q[i];
                lk_perm = lk_perm | perm_q[i];
            end
        end
    end

    assign lk_hit = |match;

    // Valid bits and round-robin victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            victim_q <= '0;
        end else if (flush_en) begin
            vld_q    <= '0;
        end else if (ins_en) begin
            vld_q[victim_q] <= 1'b1;
            victim_q <= (victim_q == LAST_IDX) ? '0 : victim_q + 1'b1;
        end
    end

    // Entry payload storage, no reset needed
    for (genvar g = 0; g < ENTRIES; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (ins_en && !flush_en && (victim_q == IDX_W'(g))) begin
                tag_q[g]  <= ins_vpn;
                pfn_q[g]  <= ins_pfn;
                perm_q[g] <= ins_perm;
            end
        end
    end

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm (
    input  xlat_pkg::acc_e               acc,
    input  logic [xlat_pkg::PERM_W-1:0]  perm,
    output logic                         allow
);
    always_comb begin
        unique case (acc)
            xlat_pkg::ACC_READ:  allow = perm[xlat_pkg::PERM_RD];
            xlat_pkg::ACC_WRITE: allow = perm[xlat_pkg::PERM_WR];
            xlat_pkg::ACC_EXEC:  allow = perm[xlat_pkg::PERM_EX];
            xlat_pkg::ACC_RSVD:  allow = 1'b0;
            default:             allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            flush,
    input  logic            tlb_hit,
    input  logic            walk_rsp_valid,
    input  logic            walk_rsp_fault,
    output xlat_pkg::st_e   state,
    output logic            req_ready,
    output logic            cap_en,
    output logic            walk_req_valid,
    output logic            ins_en,
    output logic            flush_en,
    output logic            rsp_lookup,
    output logic            rsp_walk_fault
);
    import xlat_pkg::*;

    st_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!flush && req_valid && !tlb_hit) state_d = ST_WALK;
            end
            ST_WALK: begin
                if (walk_rsp_valid) state_d = walk_rsp_fault ? ST_IDLE : ST_REPLAY;
            end
            ST_REPLAY: begin
                state_d = tlb_hit ? ST_IDLE : ST_WALK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        cap_en         = 1'b0;
        walk_req_valid = 1'b0;
        ins_en         = 1'b0;
        flush_en       = 1'b0;
        rsp_lookup     = 1'b0;
        rsp_walk_fault = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                flush_en   = flush;
                req_ready  = !flush;
                cap_en     = !flush && req_valid && !tlb_hit;
                rsp_lookup = !flush && req_valid && tlb_hit;
            end
            ST_WALK: begin
                walk_req_valid = 1'b1;
                ins_en         = walk_rsp_valid && !walk_rsp_fault;
                rsp_walk_fault = walk_rsp_valid && walk_rsp_fault;
            end
            ST_REPLAY: begin
                rsp_lookup = tlb_hit;
            end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
    parameter int VA_W    = 14,
    parameter int OFS_W   = 6,
    parameter int PFN_W   = 8,
    parameter int ENTRIES = 8,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PA_W   = PFN_W + OFS_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [VA_W-1:0]              req_vaddr,
    input  logic [1:0]                   req_acc,
    output logic                         rsp_valid,
    output logic [PA_W-1:0]              rsp_paddr,
    output logic [1:0]                   rsp_fault,
    output logic                         walk_req_valid,
    output logic [VPN_W-1:0]             walk_req_vpn,
    input  logic                         walk_rsp_valid,
    input  logic                         walk_rsp_fault,
    input  logic [PFN_W-1:0]             walk_rsp_pfn,
    input  logic [xlat_pkg::PERM_W-1:0]  walk_rsp_prot
);
    import xlat_pkg::*;

    localparam logic [VA_W-1:0] OFS_MASK = VA_W'((1 << OFS_W) - 1);
    localparam logic [VA_W-1:0] VPN_MASK = ~OFS_MASK;

    st_e               state;
    logic              cap_en, ins_en, flush_en, rsp_lookup, rsp_walk_fault;
    logic              tlb_hit, allow;
    logic [PFN_W-1:0]  hit_pfn;
    logic [PERM_W-1:0] hit_perm;
    logic [VA_W-1:0]   held_va_q;
    acc_e              held_acc_q;
    logic [VA_W-1:0]   lk_va;
    acc_e              lk_acc;
    logic [VPN_W-1:0]  lk_vpn;
    logic [OFS_W-1:0]  lk_ofs;
    flt_e              fault;

    // Captured access for walk and replay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_va_q  <= '0;
            held_acc_q <= ACC_READ;
        end else if (cap_en) begin
            held_va_q  <= req_vaddr;
            held_acc_q <= acc_e'(req_acc);
        end
    end

    assign lk_va  = (state == ST_REPLAY) ? held_va_q  : req_vaddr;
    assign lk_acc = (state == ST_REPLAY) ? held_acc_q : acc_e'(req_acc);
    assign lk_vpn = VPN_W'((lk_va & VPN_MASK) >> OFS_W);
    assign lk_ofs = OFS_W'(lk_va & OFS_MASK);

    xlat_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .flush          (flush),
        .tlb_hit        (tlb_hit),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_fault (walk_rsp_fault),
        .state          (state),
        .req_ready      (req_ready),
        .cap_en         (cap_en),
        .walk_req_valid (walk_req_valid),
        .ins_en         (ins_en),
        .flush_en       (flush_en),
        .rsp_lookup     (rsp_lookup),
        .rsp_walk_fault (rsp_walk_fault)
    );

    xlat_tlb #(
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ENTRIES (ENTRIES)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_en (flush_en),
        .lk_vpn   (lk_vpn),
        .lk_hit   (tlb_hit),
        .lk_pfn   (hit_pfn),
        .lk_perm  (hit_perm),
        .ins_en   (ins_en),
        .ins_vpn  (walk_req_vpn),
        .ins_pfn  (walk_rsp_pfn),
        .ins_perm (walk_rsp_prot)
    );

    xlat_perm u_perm (
        .acc   (lk_acc),
        .perm  (hit_perm),
        .allow (allow)
    );

    assign walk_req_vpn = VPN_W'((held_va_q & VPN_MASK) >> OFS_W);

    always_comb begin
        if (rsp_walk_fault) fault = FLT_SEG;
        else if (!allow)    fault = FLT_PROT;
        else                fault = FLT_NONE;
    end

    assign rsp_valid = rsp_lookup || rsp_walk_fault;
    assign rsp_fault = rsp_valid ? fault : FLT_NONE;
    assign rsp_paddr = (rsp_valid && fault == FLT_NONE)
                     ? ((PA_W'(hit_pfn) << OFS_W) | PA_W'(lk_ofs))
                     : '0;

endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
    parameter int VPN_W = 8,
    parameter int PA_W  = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault,
    input logic             walk_req_valid,
    input logic [VPN_W-1:0] walk_req_vpn,
    input logic             walk_rsp_valid,
    input logic             walk_rsp_fault
);
    // R2: a served lookup never coincides with a walk request
    assert_hit_no_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd2) |-> !walk_req_valid);

    // R3: faults carry a zero address
    assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    // R3: code 3 is never reported
    assert_fault_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));

    // R4: no new request while walking
    assert_walk_blocks_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready);

    // R4: walked page held steady until answered
    assert_walk_vpn_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (!walk_req_valid || $stable(walk_req_vpn)));

    // R5: a good walk answer is followed by the replay response
    assert_replay_follows_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && !walk_rsp_fault) |=>
        (rsp_valid && rsp_fault != 2'd2 && !walk_req_valid));

    // R6: faulting walk reported in the same cycle
    assert_walk_fault_reported_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && walk_rsp_fault) |-> (rsp_valid && rsp_fault == 2'd2));

    // R8: flush blocks acceptance
    assert_flush_blocks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready);
endmodule

bind xlat_unit xlat_unit_chk #(
    .VPN_W (VPN_W),
    .PA_W  (PA_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_fault      (rsp_fault),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_rsp_fault (walk_rsp_fault)
);

// File: tb/test_xlat_unit.sv
module test_xlat_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [13:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        walk_req_valid;
    logic [7:0]  walk_req_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic [7:0]  walk_rsp_pfn = '0;
    logic [2:0]  walk_rsp_prot = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_unit i_xlat_unit (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
        .walk_rsp_pfn(walk_rsp_pfn), .walk_rsp_prot(walk_rsp_prot)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Access expected to hit: response in the request cycle
    task automatic hit_access(input string tag, input logic [13:0] va, input logic [1:0] acc,
                              input int exp_fault, input int exp_pa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        #1;
        chk({tag, " R1 rsp_valid"}, rsp_valid, 1);
        chk({tag, " R3 fault"}, rsp_fault, exp_fault);
        chk({tag, " R1 paddr"}, rsp_paddr, exp_pa);
        chk({tag, " R2 no walk"}, walk_req_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Access expected to miss, walker answers after lat cycles
    task automatic miss_access(input string tag, input logic [13:0] va, input logic [1:0] acc,
                               input logic [7:0] pfn, input logic [2:0] prot, input bit wfault,
                               input int lat, input bit flush_mid,
                               input int exp_fault, input int exp_pa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        #1;
        chk({tag, " R4 no rsp on miss"}, rsp_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk({tag, " R4 walk_req_valid"}, walk_req_valid, 1);
        chk({tag, " R4 walk vpn"}, walk_req_vpn, int'(va >> 6));
        chk({tag, " R4 ready low"}, req_ready, 0);
        if (flush_mid) flush = 1'b1;
        for (int i = 0; i < lat; i++) @(negedge clk);
        walk_rsp_valid = 1'b1; walk_rsp_fault = wfault;
        walk_rsp_pfn = pfn; walk_rsp_prot = prot;
        #1;
        if (wfault) begin
            chk({tag, " R6 seg rsp"}, rsp_valid, 1);
            chk({tag, " R6 seg code"}, rsp_fault, 2);
            chk({tag, " R6 seg paddr"}, rsp_paddr, 0);
        end else begin
            chk({tag, " R5 no rsp at fill"}, rsp_valid, 0);
        end
        @(negedge clk);
        walk_rsp_valid = 1'b0; walk_rsp_fault = 1'b0;
        if (!wfault) begin
            #1;
            chk({tag, " R5 replay rsp"}, rsp_valid, 1);
            chk({tag, " R5 replay fault"}, rsp_fault, exp_fault);
            chk({tag, " R5 replay paddr"}, rsp_paddr, exp_pa);
            chk({tag, " R5 no second walk"}, walk_req_valid, 0);
            @(negedge clk);
        end
        flush = 1'b0;
    endtask

    function automatic logic [13:0] pg(input int vpn, input int ofs);
        return 14'((vpn << 6) | ofs);
    endfunction

    task automatic t_reset();
        #1;
        chk("reset req_ready", req_ready, 1);
        chk("reset rsp_valid", rsp_valid, 0);
        chk("reset walk_req_valid", walk_req_valid, 0);
    endtask

    task automatic t_basic();
        // R1: page 254 -> frame 55, 0x3F80 -> 0x0DC0 after fill
        miss_access("basic_miss", 14'h3F80, 2'd0, 8'd55, 3'b011, 0, 2, 0, 0, 14'h0DC0);
        hit_access("basic_hit_R1", 14'h3F85, 2'd0, 0, 14'h0DC5);
        hit_access("basic_write_R3", 14'h3F80, 2'd1, 0, 14'h0DC0);
        hit_access("basic_exec_R3", 14'h3F80, 2'd2, 1, 0);
        hit_access("basic_rsvd_R3", 14'h3FBF, 2'd3, 1, 0);
    endtask

    task automatic t_walk_fault();
        // R6: fault, then same access misses again
        miss_access("wfault_a", pg(100, 0), 2'd0, 8'd0, 3'b000, 1, 1, 0, 2, 0);
        miss_access("wfault_b_R6", pg(100, 0), 2'd0, 8'd0, 3'b000, 1, 0, 0, 2, 0);
    endtask

    task automatic t_round_robin();
        // R7: entries 1..7 get pages 1..7, page 8 evicts page 254 (entry 0)
        for (int n = 1; n <= 8; n++)
            miss_access("rr_fill_R7", pg(n, 42), 2'd2, 8'(n + 16), 3'b111, 0, n % 3, 0,
                        0, ((n + 16) << 6) | 42);
        hit_access("rr_hit8_R7", pg(8, 1), 2'd0, 0, (24 << 6) | 1);
        miss_access("rr_254_evicted_R7", 14'h3F80, 2'd0, 8'd55, 3'b011, 0, 1, 0, 0, 14'h0DC0);
        hit_access("rr_hit2_R7", pg(2, 3), 2'd1, 0, (18 << 6) | 3);
        miss_access("rr_1_evicted_R7", pg(1, 0), 2'd0, 8'd17, 3'b111, 0, 0, 0, 0, 17 << 6);
        hit_access("rr_hit3_R7", pg(3, 63), 2'd0, 0, (19 << 6) | 63);
    endtask

    task automatic t_replay_prot();
        // R3/R5: replay of a denied write reports protection fault
        miss_access("replay_prot_R3", pg(200, 5), 2'd1, 8'd99, 3'b001, 0, 1, 0, 1, 0);
        hit_access("replay_prot_read_R3", pg(200, 5), 2'd0, 0, (99 << 6) | 5);
    endtask

    task automatic t_flush_idle();
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk("flush R8 ready low", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        miss_access("flush_R8_a", pg(3, 0), 2'd0, 8'd19, 3'b111, 0, 1, 0, 0, 19 << 6);
        miss_access("flush_R8_b", pg(200, 0), 2'd0, 8'd99, 3'b001, 0, 0, 0, 0, 99 << 6);
    endtask

    task automatic t_flush_busy();
        // R9: flush during walk and replay has no effect
        miss_access("flushbusy_R9", pg(9, 7), 2'd0, 8'd33, 3'b001, 0, 2, 1, 0, (33 << 6) | 7);
        hit_access("flushbusy_hit_R9", pg(9, 8), 2'd0, 0, (33 << 6) | 8);
        hit_access("flushbusy_old_R9", pg(3, 1), 2'd0, 0, (19 << 6) | 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_walk_fault();
        t_round_robin();
        t_replay_prot();
        t_flush_idle();
        t_flush_busy();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule